// File: doc/BRIEF.md
# Dynamic Power-Domain Gating Controller

This block is the state machine that manages three switchable power domains while a device sits in standby. Domain 0 holds the peripherals, domain 1 holds the DMA controller and domain 2 holds the CPU. While the CPU stays asleep, the controller wakes the peripheral domain on a peripheral event. It then wakes the DMA domain on a qualified DMA request. After the transfer beat finishes, it returns both to retention without software help. A wake interrupt ends standby and brings every domain back to full operation.

Each domain has an active control and a retention control. The controller also selects the main or the low-power core regulator. Clock requests for the peripheral, DMA and CPU clocks are held low for a fixed, parameterised power-up interval after the domain that owns each clock turns active. A DMA request counts only when its channel is enabled and that channel is allowed to run in standby. Per-domain enable bits allow on-demand gating of domain 0 and domain 1 separately.

Top module: `dyn_gate_ctrl`

## Requirements
- R1: After reset, all three domains are active (`pdActive`=3'b111, `pdRetain`=3'b000), `mainReg`=1 and all three clock requests are 1.
- R2: When `standbyReq` is 1 in full operation, the next cycle has all domains in retention (`pdActive`=3'b000), `mainReg`=0 and all clock requests at 0.
- R3: In standby, a `periphEvent` with `gateEnPd0`=1 makes domain 0 active (`pdActive`=3'b001) with `mainReg`=1 in the next cycle. With `gateEnPd0`=0 the event is ignored and all domains stay in retention.
- R4: A clock request rises exactly `PWRUP_CYCLES` cycles after the cycle in which its domain first shows active. This applies to `periphClkEn` after domain 0 wakes, `dmaClkEn` after domain 1 wakes, and all clocks after a wake interrupt.
- R5: While domain 0 runs a task (`periphClkEn`=1), channel i raises a DMA trigger only if `dmaReq[i]`, `chEnable[i]` and `chRunStby[i]` are all 1. The next cycle then has `pdActive`=3'b011. Any other combination is ignored, and domain 1 stays in retention.
- R6: With `gateEnPd1`=0, even a fully qualified DMA request leaves domain 1 in retention.
- R7: `dmaClkEn` is 1 only while domain 1 is active and has been active since the previous cycle.
- R8: A `dmaBeatDone` with no qualified request present returns all domains to retention in the next cycle, with `mainReg`=0 and all clock requests at 0.
- R9: A `dmaBeatDone` that coincides with a qualified request keeps domains 0 and 1 active with `dmaClkEn`=1.
- R10: Domain 2 is never active during sleepwalking. `pdActive[2]`=1 only when all three domains are active, and `cpuClkEn` stays 0 through sleepwalking.
- R11: A `wakeIrq` in any standby or sleepwalking state makes the next cycle `pdActive`=3'b111 with `mainReg`=1. Full operation with all clocks follows after the power-up interval.
- R12: A `wakeIrq` in the same cycle as `dmaBeatDone` takes priority: domains go active rather than back to retention.
- R13: A `periphDone` while domain 0 runs its task, with no DMA trigger, returns all domains to retention in the next cycle.
- R14: `pdRetain` is the bitwise complement of `pdActive` in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| standbyReq | input | 1 | Request to enter standby from full operation |
| gateEnPd0 | input | 1 | Allows on-demand wake of domain 0 |
| gateEnPd1 | input | 1 | Allows on-demand wake of domain 1 |
| periphEvent | input | 1 | Event pulse routed to a domain-0 peripheral |
| dmaReq | input | NUM_CH | Per-channel DMA request from a peripheral |
| chEnable | input | NUM_CH | Per-channel enable |
| chRunStby | input | NUM_CH | Per-channel run-in-standby permission |
| dmaBeatDone | input | 1 | DMA beat transfer finished |
| periphDone | input | 1 | Peripheral task finished with no DMA needed |
| wakeIrq | input | 1 | Wake interrupt from a peripheral |
| pdActive | output | 3 | Active control, bit n for domain n |
| pdRetain | output | 3 | Retention control, bit n for domain n |
| mainReg | output | 1 | 1 selects main regulator, 0 the low-power one |
| periphClkEn | output | 1 | Peripheral clock request |
| dmaClkEn | output | 1 | DMA bus clock request |
| cpuClkEn | output | 1 | CPU clock request |

## Verification
The hardest condition to reach is a DMA request that arrives while the peripheral domain is already up and its clock running. Reaching it needs a standby entry, a qualified event and a full power-up wait before the request lines matter. The bench repeats that walk for every combination of request, enable and run-in-standby bits over all four channels. It then either finishes the beat or releases the peripheral, and so lands back in standby for the next pattern. The coincident cases, a beat ending together with a fresh request or together with a wake interrupt, are driven in the same single cycle after the DMA clock is granted.

// File: rtl/dgc_pkg.sv
package dgc_pkg;
  typedef enum logic [2:0] {
    ST_RUN, ST_STBY, ST_P0UP, ST_WALK, ST_P1UP, ST_XFER, ST_WAKE
  } dgcState_e;

  typedef struct packed {
    logic cntLoad;
  } ctrlStrobe_t;

  typedef struct packed {
    logic cntDone;
    logic dmaTrig;
  } dpFlag_t;
endpackage

// File: rtl/dgc_datapath.sv
module dgc_datapath
  import dgc_pkg::*;
#(
  parameter int NUM_CH       = 4,
  parameter int PWRUP_CYCLES = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic              gateEnPd1,
  input  logic [NUM_CH-1:0] dmaReq,
  input  logic [NUM_CH-1:0] chEnable,
  input  logic [NUM_CH-1:0] chRunStby,
  output dpFlag_t           flags
);
  localparam int CW = $clog2(PWRUP_CYCLES + 1);
  localparam logic [CW-1:0] LOAD_VAL = CW'(PWRUP_CYCLES - 1);

  logic [CW-1:0]     upCnt;
  logic [NUM_CH-1:0] chQual;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_qual
    assign chQual[i] = dmaReq[i] & chEnable[i] & chRunStby[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN)                upCnt <= '0;
    else if (strobe.cntLoad)  upCnt <= LOAD_VAL;
    else if (upCnt != '0)     upCnt <= upCnt - 1'b1;
  end

  assign flags.cntDone = (upCnt == '0) && !strobe.cntLoad;
  assign flags.dmaTrig = (|chQual) && gateEnPd1;
endmodule

// File: rtl/dgc_control.sv
module dgc_control
  import dgc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        standbyReq,
  input  logic        gateEnPd0,
  input  logic        periphEvent,
  input  logic        dmaBeatDone,
  input  logic        periphDone,
  input  logic        wakeIrq,
  input  dpFlag_t     flags,
  output ctrlStrobe_t strobe,
  output logic [2:0]  pdActive,
  output logic [2:0]  pdRetain,
  output logic        mainReg,
  output logic        periphClkEn,
  output logic        dmaClkEn,
  output logic        cpuClkEn
);
  dgcState_e state, nxt;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_RUN;
    else       state <= nxt;
  end

  always_comb begin
    nxt = state;
    strobe.cntLoad = 1'b0;
    if (state != ST_RUN && state != ST_WAKE && wakeIrq) begin
      nxt = ST_WAKE;
      strobe.cntLoad = 1'b1;
    end else begin
      case (state)
        ST_RUN:  if (standbyReq) nxt = ST_STBY;
        ST_STBY: if (periphEvent && gateEnPd0) begin
                   nxt = ST_P0UP;
                   strobe.cntLoad = 1'b1;
                 end
        ST_P0UP: if (flags.cntDone) nxt = ST_WALK;
        ST_WALK: if (flags.dmaTrig) begin
                   nxt = ST_P1UP;
                   strobe.cntLoad = 1'b1;
                 end else if (periphDone) nxt = ST_STBY;
        ST_P1UP: if (flags.cntDone) nxt = ST_XFER;
        ST_XFER: if (dmaBeatDone && !flags.dmaTrig) nxt = ST_STBY;
        ST_WAKE: if (flags.cntDone) nxt = ST_RUN;
        default: nxt = ST_RUN;
      endcase
    end
  end

  always_comb begin
    pdActive = 3'b000; pdRetain = 3'b111; mainReg = 1'b1;
    periphClkEn = 1'b0; dmaClkEn = 1'b0; cpuClkEn = 1'b0;
    case (state)
      ST_RUN:  begin pdActive = 3'b111; pdRetain = 3'b000;
                     periphClkEn = 1'b1; dmaClkEn = 1'b1; cpuClkEn = 1'b1; end
      ST_STBY: mainReg = 1'b0;
      ST_P0UP: begin pdActive = 3'b001; pdRetain = 3'b110; end
      ST_WALK: begin pdActive = 3'b001; pdRetain = 3'b110; periphClkEn = 1'b1; end
      ST_P1UP: begin pdActive = 3'b011; pdRetain = 3'b100; periphClkEn = 1'b1; end
      ST_XFER: begin pdActive = 3'b011; pdRetain = 3'b100;
                     periphClkEn = 1'b1; dmaClkEn = 1'b1; end
      ST_WAKE: begin pdActive = 3'b111; pdRetain = 3'b000; end
      default: mainReg = 1'b0;
    endcase
  end
endmodule

// File: rtl/dyn_gate_ctrl.sv
module dyn_gate_ctrl
  import dgc_pkg::*;
#(
  parameter int NUM_CH       = 4,
  parameter int PWRUP_CYCLES = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              standbyReq,
  input  logic              gateEnPd0,
  input  logic              gateEnPd1,
  input  logic              periphEvent,
  input  logic [NUM_CH-1:0] dmaReq,
  input  logic [NUM_CH-1:0] chEnable,
  input  logic [NUM_CH-1:0] chRunStby,
  input  logic              dmaBeatDone,
  input  logic              periphDone,
  input  logic              wakeIrq,
  output logic [2:0]        pdActive,
  output logic [2:0]        pdRetain,
  output logic              mainReg,
  output logic              periphClkEn,
  output logic              dmaClkEn,
  output logic              cpuClkEn
);
  ctrlStrobe_t strobe;
  dpFlag_t     flags;

  dgc_datapath #(.NUM_CH(NUM_CH), .PWRUP_CYCLES(PWRUP_CYCLES)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .gateEnPd1(gateEnPd1),
    .dmaReq(dmaReq), .chEnable(chEnable), .chRunStby(chRunStby), .flags(flags)
  );

  dgc_control u_ctl (
    .clk(clk), .rstN(rstN), .standbyReq(standbyReq), .gateEnPd0(gateEnPd0),
    .periphEvent(periphEvent), .dmaBeatDone(dmaBeatDone), .periphDone(periphDone),
    .wakeIrq(wakeIrq), .flags(flags), .strobe(strobe), .pdActive(pdActive),
    .pdRetain(pdRetain), .mainReg(mainReg), .periphClkEn(periphClkEn),
    .dmaClkEn(dmaClkEn), .cpuClkEn(cpuClkEn)
  );
endmodule

// File: rtl/dgc_checker.sv
module dgc_checker (
  input logic       clk,
  input logic       rstN,
  input logic       standbyReq,
  input logic       wakeIrq,
  input logic [2:0] pdActive,
  input logic [2:0] pdRetain,
  input logic       mainReg,
  input logic       periphClkEn,
  input logic       dmaClkEn,
  input logic       cpuClkEn
);
  AST_RETAIN_COMPLEMENT: assert property (@(posedge clk) disable iff (!rstN)
    pdRetain == ~pdActive);                                            // R14
  AST_PERIPH_CLK_AFTER_UP: assert property (@(posedge clk) disable iff (!rstN)
    periphClkEn |-> (pdActive[0] && $past(pdActive[0])));              // R4
  AST_DMA_CLK_AFTER_UP: assert property (@(posedge clk) disable iff (!rstN)
    dmaClkEn |-> (pdActive[1] && $past(pdActive[1])));                 // R7
  AST_CPU_DOMAIN_ONLY_FULL: assert property (@(posedge clk) disable iff (!rstN)
    pdActive[2] |-> (pdActive == 3'b111));                             // R10
  AST_STANDBY_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    (cpuClkEn && standbyReq) |=> (pdActive == 3'b000 && !mainReg));    // R2
  AST_WAKE_PRIORITY: assert property (@(posedge clk) disable iff (!rstN)
    (wakeIrq && !pdActive[2]) |=> (pdActive == 3'b111 && mainReg));    // R11
  AST_LOWPOWER_ONLY_RETAINED: assert property (@(posedge clk) disable iff (!rstN)
    !mainReg |-> (pdActive == 3'b000));                                // R8
endmodule

bind dyn_gate_ctrl dgc_checker u_chk (
  .clk(clk), .rstN(rstN), .standbyReq(standbyReq), .wakeIrq(wakeIrq),
  .pdActive(pdActive), .pdRetain(pdRetain), .mainReg(mainReg),
  .periphClkEn(periphClkEn), .dmaClkEn(dmaClkEn), .cpuClkEn(cpuClkEn)
);

// File: tb/sim_dyn_gate_ctrl.sv
module sim_dyn_gate_ctrl;
  localparam int NCH = 4;
  localparam int PU  = 3;

  logic clk = 1'b0, rstN = 1'b0;
  logic standbyReq = 0, gateEnPd0 = 0, gateEnPd1 = 0, periphEvent = 0;
  logic [NCH-1:0] dmaReq = '0, chEnable = '0, chRunStby = '0;
  logic dmaBeatDone = 0, periphDone = 0, wakeIrq = 0;
  logic [2:0] pdActive, pdRetain;
  logic mainReg, periphClkEn, dmaClkEn, cpuClkEn;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dyn_gate_ctrl #(.NUM_CH(NCH), .PWRUP_CYCLES(PU)) u0 (
    .clk(clk), .rstN(rstN), .standbyReq(standbyReq), .gateEnPd0(gateEnPd0),
    .gateEnPd1(gateEnPd1), .periphEvent(periphEvent), .dmaReq(dmaReq),
    .chEnable(chEnable), .chRunStby(chRunStby), .dmaBeatDone(dmaBeatDone),
    .periphDone(periphDone), .wakeIrq(wakeIrq), .pdActive(pdActive),
    .pdRetain(pdRetain), .mainReg(mainReg), .periphClkEn(periphClkEn),
    .dmaClkEn(dmaClkEn), .cpuClkEn(cpuClkEn)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // observed vector: {pdActive, pdRetain, mainReg, periphClk, dmaClk, cpuClk}
  function automatic logic [31:0] obs();
    return {22'd0, pdActive, pdRetain, mainReg, periphClkEn, dmaClkEn, cpuClkEn};
  endfunction

  function automatic logic [31:0] expv(input logic [2:0] act, input logic mr,
                                       input logic pc, input logic dc, input logic cc);
    return {22'd0, act, ~act, mr, pc, dc, cc};
  endfunction

  task automatic tick();
    @(posedge clk); #1;
    standbyReq = 0; periphEvent = 0; dmaReq = '0;
    dmaBeatDone = 0; periphDone = 0; wakeIrq = 0;
  endtask

  task automatic toWalk();
    periphEvent = 1; tick();
    repeat (PU) tick();
  endtask

  task automatic toXfer();
    toWalk();
    dmaReq = 4'b0001; tick();
    repeat (PU) tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    chk("R1 reset", obs(), expv(3'b111, 1, 1, 1, 1));
    chk("R14 reset retain", {29'd0, pdRetain}, 32'd0);

    standbyReq = 1; tick();
    chk("R2 standby entry", obs(), expv(3'b000, 0, 0, 0, 0));

    periphEvent = 1; tick();
    chk("R3 event ignored gate off", obs(), expv(3'b000, 0, 0, 0, 0));

    gateEnPd0 = 1;
    periphEvent = 1; tick();
    chk("R3 event wakes pd0", obs(), expv(3'b001, 1, 0, 0, 0));
    for (int i = 1; i < PU; i++) begin
      tick();
      chk("R4 periph clk held", obs(), expv(3'b001, 1, 0, 0, 0));
    end
    tick();
    chk("R4 periph clk granted", obs(), expv(3'b001, 1, 1, 0, 0));

    // sweep every request/enable/run-in-standby combination
    gateEnPd1 = 1;
    for (int c = 0; c < 4096; c++) begin
      logic q;
      chEnable  = c[7:4];
      chRunStby = c[11:8];
      dmaReq    = c[3:0];
      q = |(c[3:0] & c[7:4] & c[11:8]);
      tick();
      chk("R5 qualify", obs(), q ? expv(3'b011, 1, 1, 0, 0) : expv(3'b001, 1, 1, 0, 0));
      if (q) begin
        repeat (PU - 1) tick();
        chk("R10 cpu stays retained", obs(), expv(3'b011, 1, 1, 0, 0));
        tick();
        chk("R7 dma clk granted", obs(), expv(3'b011, 1, 1, 1, 0));
        dmaBeatDone = 1; tick();
        chk("R8 beat done retention", obs(), expv(3'b000, 0, 0, 0, 0));
      end else begin
        periphDone = 1; tick();
        chk("R13 periph done retention", obs(), expv(3'b000, 0, 0, 0, 0));
      end
      toWalk();
    end

    // gate of pd1 off: qualified requests ignored
    gateEnPd1 = 0; chEnable = '1; chRunStby = '1;
    for (int r = 1; r < 16; r++) begin
      dmaReq = r[3:0]; tick();
      chk("R6 pd1 gate off", obs(), expv(3'b001, 1, 1, 0, 0));
    end
    gateEnPd1 = 1;
    periphDone = 1; tick();

    // beat done with a pending qualified request
    toXfer();
    dmaBeatDone = 1; dmaReq = 4'b1000; tick();
    chk("R9 pending keeps pd1", obs(), expv(3'b011, 1, 1, 1, 0));
    dmaBeatDone = 1; tick();
    chk("R8 beat done no pending", obs(), expv(3'b000, 0, 0, 0, 0));

    // wake coinciding with beat done
    toXfer();
    dmaBeatDone = 1; wakeIrq = 1; tick();
    chk("R12 wake over beat done", obs(), expv(3'b111, 1, 0, 0, 0));
    for (int i = 1; i < PU; i++) begin
      tick();
      chk("R11 wake power-up hold", obs(), expv(3'b111, 1, 0, 0, 0));
    end
    tick();
    chk("R11 full run after wake", obs(), expv(3'b111, 1, 1, 1, 1));

    // wake from plain standby
    standbyReq = 1; tick();
    wakeIrq = 1; tick();
    chk("R11 wake from standby", obs(), expv(3'b111, 1, 0, 0, 0));
    repeat (PU) tick();
    chk("R4 clocks after wake", obs(), expv(3'b111, 1, 1, 1, 1));

    // wake during peripheral power-up
    standbyReq = 1; tick();
    periphEvent = 1; tick();
    wakeIrq = 1; tick();
    chk("R11 wake during pd0 power-up", obs(), expv(3'b111, 1, 0, 0, 0));
    repeat (PU) tick();
    chk("R11 run after wake", obs(), expv(3'b111, 1, 1, 1, 1));

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule